// File: doc/BRIEF.md
# Pointer-Relative Short Load/Store Unit

This unit executes the compact 16-bit memory instructions that address data relative to a base pointer register. It decodes the instruction halfword and extracts a displacement. The displacement is scaled to the access size and always zero-extended. The unit adds it to the pointer value and issues one memory request. Loads wait for the returned data, sign- or zero-extend it to the register width, and then write it back to the destination register named in the instruction. Byte stores send the low byte of the second register operand to memory and write nothing back.

The unit takes one instruction at a time and raises `ready` while it can accept another. A four-state machine sequences each access. In IDLE it accepts a recognised instruction and moves to REQ. REQ holds the request until the grant arrives. On that grant a load moves to WAIT and a store returns to IDLE. WAIT moves to WB when read data is valid. WB produces a one-cycle writeback pulse and returns to IDLE. An unrecognised encoding is dropped in IDLE and no access is made.

Top module: `slsu_unit`

## Requirements
- R1: After reset, `ready` is 1 and both `mem_req` and `wb_en` are 0.
- R2: The access address is `ptr_val` plus the zero-extended, scaled displacement, modulo 2^ADDR_W. A displacement with its top bit set still adds a positive amount.
- R3: When bits 10:7 are 0110, the unit performs a signed byte load. The displacement is bits 6:0, `mem_size` is 0, and the byte is sign-extended.
- R4: When bits 10:4 are 0000110, the unit performs an unsigned byte load. The displacement is bits 3:0, `mem_size` is 0, and the byte is zero-extended.
- R5: When bits 10:7 are 1000, the unit performs a signed halfword load. The displacement is {bits 6:0, 0}, `mem_size` is 1, and the halfword is sign-extended.
- R6: When bits 10:4 are 0000111, the unit performs an unsigned halfword load. The displacement is {bits 3:0, 0}, `mem_size` is 1, and the halfword is zero-extended.
- R7: When bits 10:7 are 1010 and bit 0 is 0, the unit performs a word load. The displacement is {bits 6:1, 00}, `mem_size` is 2, and the data is written back unchanged.
- R8: When bits 10:7 are 0111, the unit performs a byte store. The displacement is bits 6:0, `mem_size` is 0, and `mem_we` is 1. `mem_wdata` is the low byte of `reg2_val` with zeros above it, and no writeback follows.
- R9: While `mem_req` is high and `mem_gnt` is low, the request stays high and the address, size and write flag stay unchanged.
- R10: A load raises `wb_en` for exactly one cycle, in the cycle after the one in which `mem_rvalid` is seen in WAIT. `wb_idx` equals instruction bits 15:11. Read data that arrives before the grant is ignored.
- R11: Any other encoding, including 1010 with bit 0 set, makes no request and no writeback, and `ready` stays 1.
- R12: An issue is taken only while `ready` is 1. An `issue_valid` seen while the unit is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_instr | input | 16 | Instruction halfword |
| ptr_val | input | ADDR_W | Base pointer register value |
| reg2_val | input | DATA_W | Second register operand (store data) |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data, right-justified |
| ready | output | 1 | Unit idle, can accept an instruction |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data, right-justified |
| wb_en | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | DATA_W | Extended load result |

## Verification
The bench tests displacements whose top bit is set, together with pointers close to the top of the address space. A design that sign-extended the displacement would then request an address below the pointer, and a design that failed to wrap would request the wrong address. Loaded bytes and halfwords with their top bit set are returned to both the signed and unsigned variants, so a swapped extension path shows up as the wrong upper bits. The bench holds off the grant, sends stray read data before the grant, and presents stray issues while the unit is busy. A unit that latched data early or accepted a second instruction would write back the wrong value or change its request. The word opcode with bit 0 set, and other unrecognised encodings, must produce no request and no writeback.

// File: rtl/slsu_pkg.sv
package slsu_pkg;

    localparam int DISP_W = 8;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } slsu_state_e;

    typedef struct packed {
        logic              legal;
        logic              store;
        logic              sext;
        acc_size_e         size;
        logic [DISP_W-1:0] disp;
        logic [IDX_W-1:0]  idx;
    } slsu_dec_t;

endpackage

// File: rtl/slsu_decode.sv
module slsu_decode
    import slsu_pkg::*;
(
    input  logic [15:0] instr,
    output slsu_dec_t   dec
);

    always_comb begin
        dec       = '0;
        dec.size  = SZ_BYTE;
        dec.idx   = instr[15:11];
        if (instr[10:4] == 7'b0000110) begin
            // unsigned byte load, 4-bit byte displacement
            dec.legal = 1'b1;
            dec.size  = SZ_BYTE;
            dec.disp  = {4'b0000, instr[3:0]};
        end else if (instr[10:4] == 7'b0000111) begin
            // unsigned halfword load, displacement scaled by two
            dec.legal = 1'b1;
            dec.size  = SZ_HALF;
            dec.disp  = {3'b000, instr[3:0], 1'b0};
        end else begin
            unique case (instr[10:7])
                4'b0110: begin
                    dec.legal = 1'b1;
                    dec.sext  = 1'b1;
                    dec.size  = SZ_BYTE;
                    dec.disp  = {1'b0, instr[6:0]};
                end
                4'b0111: begin
                    dec.legal = 1'b1;
                    dec.store = 1'b1;
                    dec.size  = SZ_BYTE;
                    dec.disp  = {1'b0, instr[6:0]};
                end
                4'b1000: begin
                    dec.legal = 1'b1;
                    dec.sext  = 1'b1;
                    dec.size  = SZ_HALF;
                    dec.disp  = {instr[6:0], 1'b0};
                end
                4'b1010: begin
                    dec.legal = ~instr[0];
                    dec.size  = SZ_WORD;
                    dec.disp  = {instr[6:1], 2'b00};
                end
                default: begin
                    dec.legal = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/slsu_agen.sv
module slsu_agen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - DISP_W;

    // displacement is always zero-extended before the add
    assign addr = base + {{PAD_W{1'b0}}, disp};

endmodule

// File: rtl/slsu_extend.sv
module slsu_extend
    import slsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  acc_size_e         size,
    input  logic              sext,
    output logic [DATA_W-1:0] ext
);

    localparam int B_PAD = DATA_W - 8;
    localparam int H_PAD = DATA_W - 16;

    logic b_fill;
    logic h_fill;

    assign b_fill = sext & raw[7];
    assign h_fill = sext & raw[15];

    always_comb begin
        unique case (size)
            SZ_BYTE: ext = {{B_PAD{b_fill}}, raw[7:0]};
            SZ_HALF: ext = {{H_PAD{h_fill}}, raw[15:0]};
            SZ_WORD: ext = raw;
            default: ext = raw;
        endcase
    end

endmodule

// File: rtl/slsu_unit.sv
module slsu_unit
    import slsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [15:0]       issue_instr,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic [DATA_W-1:0] reg2_val,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wb_en,
    output logic [4:0]        wb_idx,
    output logic [DATA_W-1:0] wb_data
);

    localparam int WD_PAD = DATA_W - 8;

    slsu_state_e state_q, state_d;
    slsu_dec_t   dec;
    logic [ADDR_W-1:0] addr_calc;
    logic [DATA_W-1:0] ext_calc;

    logic [ADDR_W-1:0] addr_q;
    acc_size_e         size_q;
    logic              we_q;
    logic              sext_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] wb_q;

    logic take_issue;
    logic unused_hi;

    assign unused_hi = ^reg2_val[DATA_W-1:8];

    slsu_decode u_dec (
        .instr (issue_instr),
        .dec   (dec)
    );

    slsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .base (ptr_val),
        .disp (dec.disp),
        .addr (addr_calc)
    );

    slsu_extend #(.DATA_W(DATA_W)) u_ext (
        .raw  (mem_rdata),
        .size (size_q),
        .sext (sext_q),
        .ext  (ext_calc)
    );

    assign take_issue = (state_q == ST_IDLE) && issue_valid && dec.legal;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_issue) state_d = ST_REQ;
            ST_REQ:  if (mem_gnt)    state_d = we_q ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (mem_rvalid) state_d = ST_WB;
            ST_WB:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            we_q    <= 1'b0;
            sext_q  <= 1'b0;
            idx_q   <= '0;
            wdata_q <= '0;
        end else if (take_issue) begin
            addr_q  <= addr_calc;
            size_q  <= dec.size;
            we_q    <= dec.store;
            sext_q  <= dec.sext;
            idx_q   <= dec.idx;
            wdata_q <= {{WD_PAD{1'b0}}, reg2_val[7:0]};
        end
    end

    // load result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                wb_q <= '0;
        else if (state_q == ST_WAIT && mem_rvalid) wb_q <= ext_calc;
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        mem_req   = 1'b0;
        wb_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: ready   = 1'b1;
            ST_REQ:  mem_req = 1'b1;
            ST_WAIT: ;
            ST_WB:   wb_en   = 1'b1;
            default: ;
        endcase
        mem_we    = we_q;
        mem_size  = size_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        wb_idx    = idx_q;
        wb_data   = wb_q;
    end

endmodule

// File: rtl/slsu_unit_chk.sv
module slsu_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_size,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              wb_en
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we));

    // R8
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_gnt |=> !wb_en && ready);

    // R8
    store_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_size == 2'd0);

    // R10
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);

    // R10
    wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_en) |-> $past(mem_rvalid));

    // R12
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || wb_en) |-> !ready);

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && wb_en));

endmodule

bind slsu_unit slsu_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_size   (mem_size),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .wb_en      (wb_en)
);

// File: tb/slsu_unit_tb.sv
module slsu_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] issue_instr = '0;
    logic [31:0] ptr_val = '0;
    logic [31:0] reg2_val = '0;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ready, mem_req, mem_we, wb_en;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, wb_data;
    logic [4:0]  wb_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slsu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .ptr_val(ptr_val), .reg2_val(reg2_val), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .ready(ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // reference decode from the requirements
    function automatic void model(input logic [15:0] ins, output bit legal, output bit st,
                                  output bit sx, output logic [1:0] sz, output logic [7:0] disp);
        legal = 1'b0; st = 1'b0; sx = 1'b0; sz = 2'd0; disp = 8'd0;
        if (ins[10:4] == 7'b0000110) begin legal = 1; sz = 0; disp = {4'd0, ins[3:0]}; end        // R4
        else if (ins[10:4] == 7'b0000111) begin legal = 1; sz = 1; disp = {3'd0, ins[3:0], 1'b0}; end // R6
        else if (ins[10:7] == 4'b0110) begin legal = 1; sx = 1; sz = 0; disp = {1'b0, ins[6:0]}; end // R3
        else if (ins[10:7] == 4'b0111) begin legal = 1; st = 1; sz = 0; disp = {1'b0, ins[6:0]}; end // R8
        else if (ins[10:7] == 4'b1000) begin legal = 1; sx = 1; sz = 1; disp = {ins[6:0], 1'b0}; end // R5
        else if (ins[10:7] == 4'b1010 && !ins[0]) begin legal = 1; sz = 2; disp = {ins[6:1], 2'b00}; end // R7
    endfunction

    function automatic logic [31:0] model_ext(input logic [31:0] d, input logic [1:0] sz, input bit sx);
        if (sz == 2'd0) return sx ? {{24{d[7]}}, d[7:0]} : {24'd0, d[7:0]};
        if (sz == 2'd1) return sx ? {{16{d[15]}}, d[15:0]} : {16'd0, d[15:0]};
        return d;
    endfunction

    function automatic logic [15:0] make_instr(input int kind);
        logic [15:0] r;
        r = 16'($urandom);
        case (kind)
            0: r[10:7] = 4'b0110;
            1: r[10:4] = 7'b0000110;
            2: r[10:7] = 4'b1000;
            3: r[10:4] = 7'b0000111;
            4: begin r[10:7] = 4'b1010; r[0] = 1'b0; end
            5: r[10:7] = 4'b0111;
            default: begin r[10:7] = 4'b1010; r[0] = 1'b1; end
        endcase
        return r;
    endfunction

    task automatic run_op(input logic [15:0] ins, input logic [31:0] ptr, input logic [31:0] r2,
                          input logic [31:0] rd, input bit noisy);
        bit legal, st, sx;
        logic [1:0] sz;
        logic [7:0] disp;
        bit first;
        bit g;
        model(ins, legal, st, sx, sz, disp);
        @(negedge clk);
        chk("R12 ready before issue", 32'(ready), 32'd1);
        issue_valid = 1'b1; issue_instr = ins; ptr_val = ptr; reg2_val = r2;
        @(negedge clk);
        issue_valid = 1'b0;
        ptr_val = 32'($urandom); reg2_val = 32'($urandom); issue_instr = 16'($urandom);
        if (!legal) begin
            chk("R11 no request", 32'(mem_req), 32'd0);
            chk("R11 ready kept", 32'(ready), 32'd1);
            @(negedge clk);
            chk("R11 no writeback", 32'(wb_en), 32'd0);
            return;
        end
        first = 1'b1;
        forever begin
            chk("R9 request held", 32'(mem_req), 32'd1);
            if (first) begin
                chk("R2 address", mem_addr, ptr + {24'd0, disp});
                chk("R3-R7 size", 32'(mem_size), 32'(sz));
                chk("R8 write flag", 32'(mem_we), 32'(st));
                if (st) chk("R8 store data", mem_wdata, {24'd0, r2[7:0]});
            end else begin
                chk("R9 address stable", mem_addr, ptr + {24'd0, disp});
            end
            first = 1'b0;
            g = ($urandom % 3) == 0;
            mem_gnt = g;
            if (noisy && !g) begin
                // R10 stray read data and R12 stray issue while busy
                mem_rvalid = 1'b1; mem_rdata = 32'($urandom);
                issue_valid = 1'b1; issue_instr = make_instr(5);
            end else begin
                mem_rvalid = 1'b0; issue_valid = 1'b0;
            end
            @(negedge clk);
            if (g) break;
        end
        mem_gnt = 1'b0; mem_rvalid = 1'b0; issue_valid = 1'b0;
        if (st) begin
            chk("R8 no writeback", 32'(wb_en), 32'd0);
            chk("R8 back to ready", 32'(ready), 32'd1);
            chk("R12 stray issue ignored", 32'(mem_req), 32'd0);
            return;
        end
        chk("R12 no new request", 32'(mem_req), 32'd0);
        repeat ($urandom % 4) begin
            chk("R10 no early writeback", 32'(wb_en), 32'd0);
            @(negedge clk);
        end
        mem_rvalid = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'($urandom);
        chk("R10 wb_en", 32'(wb_en), 32'd1);
        chk("R10 wb_idx", 32'(wb_idx), 32'(ins[15:11]));
        chk("R3-R7 wb_data", wb_data, model_ext(rd, sz, sx));
        @(negedge clk);
        chk("R10 single pulse", 32'(wb_en), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 wb_en", 32'(wb_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", 32'(ready), 32'd1);

        // directed corner cases
        run_op({5'd3, 4'b0110, 7'h7F}, 32'hFFFF_FFF0, 32'h0, 32'h0000_0080, 1'b0);   // R2 R3 wrap, sign
        run_op({5'd4, 7'b0000110, 4'hF}, 32'h1000_0000, 32'h0, 32'h1234_56FF, 1'b0); // R4
        run_op({5'd5, 4'b1000, 7'h7F}, 32'h2000_0000, 32'h0, 32'h0000_8001, 1'b0);   // R5 disp 0xFE
        run_op({5'd6, 7'b0000111, 4'hF}, 32'h0000_0100, 32'h0, 32'hAAAA_FFFF, 1'b0); // R6 disp 0x1E
        run_op({5'd7, 4'b1010, 7'h7E}, 32'h0000_0400, 32'h0, 32'h8765_4321, 1'b0);   // R7 disp 0xFC
        run_op({5'd8, 4'b0111, 7'h40}, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0, 1'b1);   // R8
        run_op({5'd9, 4'b1010, 7'h01}, 32'h0000_0000, 32'h0, 32'h0, 1'b0);           // R11
        run_op({5'd9, 4'b1111, 7'h00}, 32'h0000_0000, 32'h0, 32'h0, 1'b0);           // R11
        run_op({5'd1, 4'b0110, 7'h01}, 32'h0000_0010, 32'h0, 32'h0000_007F, 1'b1);   // R10 R12 noisy

        for (int i = 0; i < N_RANDOM; i++) begin
            run_op(make_instr(int'($urandom % 7)), 32'($urandom), 32'($urandom),
                   32'($urandom), bit'($urandom % 2));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule